// File: doc/BRIEF.md
# Paged LFSR Program Sequencer

This block produces the instruction fetch address for a small 4-bit controller. The address has two parts: a page number and a 6-bit in-page word counter. The in-page counter does not count in binary. It steps through a linear-feedback shift sequence that has been extended to cover all 64 words. The instruction decoder reports each instruction to the sequencer through one strobe per kind:

- a call into the dedicated subroutine page;
- a jump inside the current page;
- a return;
- a page select.

Each strobe comes with its operand. Any other instruction is shown by leaving every strobe low.

Jumps, returns and page selects take two cycles. While `busy_o` is high, the sequencer shows the word that follows the instruction. If the decoder reports a page select there, that page select modifies the pending jump or return instead of running on its own. A single return register and a subroutine flag support one level of calls. The start page and the page numbers of the two subroutine blocks are parameters.

Top module: `paged_lfsr_seq`

## Requirements
- R1: After reset, page_o equals START_PAGE (default 7), addr_o is 0, and busy_o and sub_o are 0. The return register holds START_PAGE and address 0.
- R2: On a cycle with busy_o low and no strobe, page_o is unchanged and addr_o steps from a to {a[4:0], fb}, where fb = ~(a[5]^a[4]) ^ (a[4:0]==5'b11111). In 64 such steps, all 64 addresses are visited and the counter returns to its starting value.
- R3: A strobe taken while busy_o is low raises busy_o for exactly one cycle. During that cycle the page is held and addr_o shows the next LFSR address after the instruction. In the busy cycle, the call, jump and return strobes are ignored; only the page-select strobe is considered.
- R4: A bare page select with operand z, issued at address a, lands at page z, address next(a).
- R5: A local jump with operand x lands at address x of the current page. If the current page is SR0_PAGE, it lands at address x of SR1_PAGE instead.
- R6: A call with operand x lands at SR0_PAGE address x and sets sub_o. If sub_o was 0, it saves (current page, next(a)) as the return address. If sub_o was already 1, the return register is unchanged.
- R7: A return lands at the address held in the return register and clears sub_o.
- R8: A local jump x followed in its busy cycle by a page select z lands at page z, address x.
- R9: A return followed in its busy cycle by a page select z lands at page z, at the in-page address held in the return register.
- R10: A call x from address a, with sub_o clear, followed in its busy cycle by a page select z, saves the return address (z, next(next(a))).
- R11: A page select that is the first instruction after a jump lands behaves as a bare page select. No pending modification carries over.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| call_i | input | 1 | Call into subroutine block SR0 |
| jump_i | input | 1 | Local jump |
| psel_i | input | 1 | Page select |
| ret_i | input | 1 | Return |
| opnd_addr_i | input | 6 | Jump or call target address |
| opnd_page_i | input | 4 | Page-select operand |
| page_o | output | 4 | Current page |
| addr_o | output | 6 | Current in-page address |
| busy_o | output | 1 | Second cycle of a two-cycle instruction |
| sub_o | output | 1 | Subroutine flag |

## Verification
In one cycle, a page select arriving during the busy cycle of a call meets two actions: the landing of the call and the saving of the return address. The same happens with a return, where the page select meets the reload from the return register. Directed sequences set up calls and returns, each with and without a page select in the busy cycle. The random phase also places page selects and stray strobes in busy cycles under every pending instruction kind. A bench model built from the requirements then predicts the page, address, flag and return target, and the results are judged against those predictions.

// File: rtl/plseq_pkg.sv
package plseq_pkg;
  typedef enum logic [2:0] {
    K_NONE = 3'd0,
    K_PSEL = 3'd1,
    K_CALL = 3'd2,
    K_JUMP = 3'd3,
    K_RET  = 3'd4
  } op_kind_e;
endpackage

// File: rtl/plseq_lfsr_step.sv
module plseq_lfsr_step #(
  parameter int          AW         = 6,
  parameter logic [AW-1:0] TAPS     = {2'b11, {(AW-2){1'b0}}},
  parameter bit          FULL_CYCLE = 1'b1
) (
  input  logic [AW-1:0] cur_i,
  output logic [AW-1:0] nxt_o
);
  localparam int LW = AW - 1;

  logic fb_base;
  logic fb;

  assign fb_base = ~^(cur_i & TAPS);

  // completion term splices the all-ones word into the cycle
  generate
    if (FULL_CYCLE) begin : g_full
      assign fb = fb_base ^ (&cur_i[LW-1:0]);
    end else begin : g_short
      assign fb = fb_base;
    end
  endgenerate

  assign nxt_o = {cur_i[LW-1:0], fb};
endmodule

// File: rtl/plseq_ctrl.sv
module plseq_ctrl
  import plseq_pkg::*;
#(
  parameter int AW = 6,
  parameter int PW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          call_i,
  input  logic          jump_i,
  input  logic          psel_i,
  input  logic          ret_i,
  input  logic [AW-1:0] opnd_addr_i,
  input  logic [PW-1:0] opnd_page_i,
  output logic          busy_o,
  output op_kind_e      kind_o,
  output logic [AW-1:0] tgt_addr_o,
  output logic [PW-1:0] tgt_page_o
);
  logic          busy_q;
  op_kind_e      kind_q;
  logic [AW-1:0] tgt_addr_q;
  logic [PW-1:0] tgt_page_q;
  logic          any_strobe;
  op_kind_e      issue_kind;

  assign any_strobe = call_i | jump_i | psel_i | ret_i;

  always_comb begin
    if (ret_i)       issue_kind = K_RET;
    else if (call_i) issue_kind = K_CALL;
    else if (jump_i) issue_kind = K_JUMP;
    else if (psel_i) issue_kind = K_PSEL;
    else             issue_kind = K_NONE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q     <= 1'b0;
      kind_q     <= K_NONE;
      tgt_addr_q <= '0;
      tgt_page_q <= '0;
    end else if (busy_q) begin
      busy_q <= 1'b0;
      kind_q <= K_NONE;
    end else if (any_strobe) begin
      busy_q     <= 1'b1;
      kind_q     <= issue_kind;
      tgt_addr_q <= opnd_addr_i;
      tgt_page_q <= opnd_page_i;
    end
  end

  assign busy_o     = busy_q;
  assign kind_o     = kind_q;
  assign tgt_addr_o = tgt_addr_q;
  assign tgt_page_o = tgt_page_q;

  AST_BUSY_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |=> !busy_q); // R3
  AST_BUSY_AFTER_ISSUE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_q && any_strobe) |=> busy_q); // R3
  AST_STROBE_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({call_i, jump_i, psel_i, ret_i})); // R3
endmodule

// File: rtl/plseq_ret_reg.sv
module plseq_ret_reg
  import plseq_pkg::*;
#(
  parameter int            AW       = 6,
  parameter int            PW       = 4,
  parameter logic [PW-1:0] START_PG = '0
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          busy_i,
  input  op_kind_e      kind_i,
  input  logic          psel_i,
  input  logic [PW-1:0] opnd_page_i,
  input  logic [PW-1:0] page_i,
  input  logic [AW-1:0] addr_i,
  input  logic [AW-1:0] addr_nxt_i,
  output logic          sub_o,
  output logic [PW-1:0] ret_page_o,
  output logic [AW-1:0] ret_addr_o
);
  logic          sub_q;
  logic [PW-1:0] ret_page_q;
  logic [AW-1:0] ret_addr_q;
  logic          call_fin;
  logic          ret_fin;

  assign call_fin = busy_i && (kind_i == K_CALL);
  assign ret_fin  = busy_i && (kind_i == K_RET);

  // save happens in the busy cycle: addr_i already holds next(a)
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sub_q      <= 1'b0;
      ret_page_q <= START_PG;
      ret_addr_q <= '0;
    end else if (call_fin) begin
      sub_q <= 1'b1;
      if (!sub_q) begin
        if (psel_i) begin
          ret_page_q <= opnd_page_i;
          ret_addr_q <= addr_nxt_i;
        end else begin
          ret_page_q <= page_i;
          ret_addr_q <= addr_i;
        end
      end
    end else if (ret_fin) begin
      sub_q <= 1'b0;
    end
  end

  assign sub_o      = sub_q;
  assign ret_page_o = ret_page_q;
  assign ret_addr_o = ret_addr_q;

  AST_SUB_SET_ON_CALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    call_fin |=> sub_q); // R6
  AST_SUB_CLR_ON_RET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ret_fin |=> !sub_q); // R7
  AST_NESTED_KEEPS_RET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (call_fin && sub_q) |=> $stable({ret_page_q, ret_addr_q})); // R6
endmodule

// File: rtl/plseq_target.sv
module plseq_target
  import plseq_pkg::*;
#(
  parameter int            AW     = 6,
  parameter int            PW     = 4,
  parameter logic [PW-1:0] SR0_PG = '0,
  parameter logic [PW-1:0] SR1_PG = '0
) (
  input  logic          busy_i,
  input  op_kind_e      kind_i,
  input  logic          psel_i,
  input  logic [PW-1:0] opnd_page_i,
  input  logic [AW-1:0] tgt_addr_i,
  input  logic [PW-1:0] tgt_page_i,
  input  logic [PW-1:0] page_i,
  input  logic [AW-1:0] addr_i,
  input  logic [AW-1:0] addr_nxt_i,
  input  logic [PW-1:0] ret_page_i,
  input  logic [AW-1:0] ret_addr_i,
  output logic [PW-1:0] page_d_o,
  output logic [AW-1:0] addr_d_o
);
  logic [PW-1:0] local_pg;

  assign local_pg = (page_i == SR0_PG) ? SR1_PG : page_i;

  always_comb begin
    page_d_o = page_i;
    addr_d_o = addr_nxt_i;
    if (busy_i) begin
      unique case (kind_i)
        K_PSEL: begin
          page_d_o = tgt_page_i;
          addr_d_o = addr_i;
        end
        K_CALL: begin
          page_d_o = SR0_PG;
          addr_d_o = tgt_addr_i;
        end
        K_JUMP: begin
          page_d_o = psel_i ? opnd_page_i : local_pg;
          addr_d_o = tgt_addr_i;
        end
        K_RET: begin
          page_d_o = psel_i ? opnd_page_i : ret_page_i;
          addr_d_o = ret_addr_i;
        end
        default: begin
          page_d_o = page_i;
          addr_d_o = addr_i;
        end
      endcase
    end
  end
endmodule

// File: rtl/paged_lfsr_seq.sv
module paged_lfsr_seq
  import plseq_pkg::*;
#(
  parameter int AW         = 6,
  parameter int PW         = 4,
  parameter int START_PAGE = 7,
  parameter int SR0_PAGE   = 0,
  parameter int SR1_PAGE   = 1,
  parameter logic [AW-1:0] TAPS = {2'b11, {(AW-2){1'b0}}},
  parameter bit FULL_CYCLE = 1'b1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          call_i,
  input  logic          jump_i,
  input  logic          psel_i,
  input  logic          ret_i,
  input  logic [AW-1:0] opnd_addr_i,
  input  logic [PW-1:0] opnd_page_i,
  output logic [PW-1:0] page_o,
  output logic [AW-1:0] addr_o,
  output logic          busy_o,
  output logic          sub_o
);
  localparam logic [PW-1:0] START_PG = PW'(START_PAGE);
  localparam logic [PW-1:0] SR0_PG   = PW'(SR0_PAGE);
  localparam logic [PW-1:0] SR1_PG   = PW'(SR1_PAGE);

  logic [PW-1:0] page_q, page_d;
  logic [AW-1:0] addr_q, addr_d, addr_nxt;
  logic          busy;
  op_kind_e      kind;
  logic [AW-1:0] tgt_addr;
  logic [PW-1:0] tgt_page;
  logic [PW-1:0] ret_page;
  logic [AW-1:0] ret_addr;
  logic          sub;

  plseq_lfsr_step #(.AW(AW), .TAPS(TAPS), .FULL_CYCLE(FULL_CYCLE)) u_step (
    .cur_i (addr_q),
    .nxt_o (addr_nxt)
  );

  plseq_ctrl #(.AW(AW), .PW(PW)) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .call_i      (call_i),
    .jump_i      (jump_i),
    .psel_i      (psel_i),
    .ret_i       (ret_i),
    .opnd_addr_i (opnd_addr_i),
    .opnd_page_i (opnd_page_i),
    .busy_o      (busy),
    .kind_o      (kind),
    .tgt_addr_o  (tgt_addr),
    .tgt_page_o  (tgt_page)
  );

  plseq_ret_reg #(.AW(AW), .PW(PW), .START_PG(START_PG)) u_ret (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .busy_i      (busy),
    .kind_i      (kind),
    .psel_i      (psel_i),
    .opnd_page_i (opnd_page_i),
    .page_i      (page_q),
    .addr_i      (addr_q),
    .addr_nxt_i  (addr_nxt),
    .sub_o       (sub),
    .ret_page_o  (ret_page),
    .ret_addr_o  (ret_addr)
  );

  plseq_target #(.AW(AW), .PW(PW), .SR0_PG(SR0_PG), .SR1_PG(SR1_PG)) u_tgt (
    .busy_i      (busy),
    .kind_i      (kind),
    .psel_i      (psel_i),
    .opnd_page_i (opnd_page_i),
    .tgt_addr_i  (tgt_addr),
    .tgt_page_i  (tgt_page),
    .page_i      (page_q),
    .addr_i      (addr_q),
    .addr_nxt_i  (addr_nxt),
    .ret_page_i  (ret_page),
    .ret_addr_i  (ret_addr),
    .page_d_o    (page_d),
    .addr_d_o    (addr_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      page_q <= START_PG;
      addr_q <= '0;
    end else begin
      page_q <= page_d;
      addr_q <= addr_d;
    end
  end

  assign page_o = page_q;
  assign addr_o = addr_q;
  assign busy_o = busy;
  assign sub_o  = sub;

  AST_PAGE_HELD_ISSUE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy |=> (page_q == $past(page_q))); // R2
  AST_ADDR_NO_STALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy |=> (addr_q != $past(addr_q))); // R2
  AST_CALL_LANDS_SR0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && kind == K_CALL) |=> (page_q == SR0_PG)); // R6
  AST_RET_LANDS_SAVED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && kind == K_RET && !psel_i) |=> (page_q == $past(ret_page) && addr_q == $past(ret_addr))); // R7
endmodule

// File: tb/paged_lfsr_seq_tb.sv
`timescale 1ns/1ps
module paged_lfsr_seq_tb;
  localparam int AW = 6;
  localparam int PW = 4;
  localparam logic [PW-1:0] START = 4'd7;
  localparam logic [PW-1:0] SR0   = 4'd0;
  localparam logic [PW-1:0] SR1   = 4'd1;
  localparam int K_NONE = 0, K_PSEL = 1, K_CALL = 2, K_JUMP = 3, K_RET = 4;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #4 clk = ~clk;

  logic          call_s = 0, jump_s = 0, psel_s = 0, ret_s = 0;
  logic [AW-1:0] ox = '0;
  logic [PW-1:0] oz = '0;
  logic [PW-1:0] page_o;
  logic [AW-1:0] addr_o;
  logic          busy_o, sub_o;

  paged_lfsr_seq u_dut (
    .clk_i(clk), .rst_ni(rst_ni),
    .call_i(call_s), .jump_i(jump_s), .psel_i(psel_s), .ret_i(ret_s),
    .opnd_addr_i(ox), .opnd_page_i(oz),
    .page_o(page_o), .addr_o(addr_o), .busy_o(busy_o), .sub_o(sub_o)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [PW-1:0] mp, mz, mrp;
  logic [AW-1:0] ma, mx, mra;
  logic          mbusy, msub;
  int            mkind;

  function automatic logic [AW-1:0] ref_next(input logic [AW-1:0] a);
    return {a[4:0], (~(a[5] ^ a[4])) ^ (a[4:0] == 5'h1f)};
  endfunction

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic chk_all(input string tag);
    chk(tag, "page", int'(page_o), int'(mp));
    chk(tag, "addr", int'(addr_o), int'(ma));
    chk(tag, "busy", int'(busy_o), int'(mbusy));
    chk(tag, "sub",  int'(sub_o),  int'(msub));
  endtask

  task automatic model_reset();
    mp = START; ma = '0; mbusy = 0; msub = 0; mkind = K_NONE;
    mx = '0; mz = '0; mrp = START; mra = '0;
  endtask

  task automatic model_edge(input logic c, input logic j, input logic p, input logic r,
                            input logic [AW-1:0] x, input logic [PW-1:0] z);
    if (!mbusy) begin
      if (c | j | p | r) begin
        mbusy = 1;
        mkind = r ? K_RET : c ? K_CALL : j ? K_JUMP : K_PSEL;
        mx = x; mz = z;
      end
      ma = ref_next(ma);
    end else begin
      mbusy = 0;
      case (mkind)
        K_PSEL: mp = mz;
        K_CALL: begin
          if (!msub) begin
            if (p) begin mrp = z; mra = ref_next(ma); end
            else begin mrp = mp; mra = ma; end
          end
          msub = 1; mp = SR0; ma = mx;
        end
        K_JUMP: begin
          mp = p ? z : ((mp == SR0) ? SR1 : mp);
          ma = mx;
        end
        K_RET: begin
          mp = p ? z : mrp; ma = mra; msub = 0;
        end
        default: ;
      endcase
      mkind = K_NONE;
    end
  endtask

  task automatic cyc(input logic c, input logic j, input logic p, input logic r,
                     input logic [AW-1:0] x, input logic [PW-1:0] z, input string tag);
    call_s = c; jump_s = j; psel_s = p; ret_s = r; ox = x; oz = z;
    @(posedge clk);
    model_edge(c, j, p, r, x, z);
    @(negedge clk);
    call_s = 0; jump_s = 0; psel_s = 0; ret_s = 0;
    chk_all(tag);
  endtask

  task automatic instr(input int kind, input logic [AW-1:0] x, input logic [PW-1:0] z,
                       input bit follow, input logic [PW-1:0] fz, input string tag);
    cyc(kind == K_CALL, kind == K_JUMP, kind == K_PSEL, kind == K_RET, x, z, tag);
    if (kind != K_NONE) cyc(0, 0, follow, 0, '0, fz, tag);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [AW-1:0] a0;
    bit seen [64];
    int nseen;
    void'($urandom(32'd1234));
    model_reset();
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    chk_all("R1");
    chk("R1", "page", int'(page_o), 7);

    // R2: full-cycle walk
    foreach (seen[k]) seen[k] = 0;
    nseen = 0;
    for (int i = 0; i < 64; i++) begin
      if (!seen[addr_o]) nseen++;
      seen[addr_o] = 1;
      cyc(0, 0, 0, 0, '0, '0, "R2");
    end
    chk("R2", "distinct", nseen, 64);
    chk("R2", "wrap", int'(addr_o), 0);

    instr(K_JUMP, 6'd5, '0, 0, '0, "R5");
    chk("R5", "page", int'(page_o), 7);
    chk("R5", "addr", int'(addr_o), 5);
    a0 = addr_o;
    instr(K_CALL, 6'd9, '0, 0, '0, "R6");
    chk("R6", "page", int'(page_o), 0);
    chk("R6", "sub", int'(sub_o), 1);
    instr(K_JUMP, 6'd3, '0, 0, '0, "R5");
    chk("R5", "sr1 page", int'(page_o), 1);
    instr(K_CALL, 6'd12, '0, 0, '0, "R6");
    instr(K_RET, '0, '0, 0, '0, "R7");
    chk("R7", "page", int'(page_o), 7);
    chk("R7", "addr", int'(addr_o), int'(ref_next(a0)));
    chk("R7", "sub", int'(sub_o), 0);

    instr(K_JUMP, 6'd20, '0, 1, 4'd3, "R8");
    chk("R8", "page", int'(page_o), 3);
    chk("R8", "addr", int'(addr_o), 20);
    a0 = addr_o;
    instr(K_CALL, 6'd7, '0, 1, 4'd5, "R10");
    instr(K_RET, '0, '0, 0, '0, "R10");
    chk("R10", "page", int'(page_o), 5);
    chk("R10", "addr", int'(addr_o), int'(ref_next(ref_next(a0))));

    a0 = addr_o;
    instr(K_CALL, 6'd1, '0, 0, '0, "R9");
    instr(K_RET, '0, '0, 1, 4'd9, "R9");
    chk("R9", "page", int'(page_o), 9);
    chk("R9", "addr", int'(addr_o), int'(ref_next(a0)));

    a0 = addr_o;
    instr(K_PSEL, '0, 4'd11, 0, '0, "R4");
    chk("R4", "page", int'(page_o), 11);
    chk("R4", "addr", int'(addr_o), int'(ref_next(a0)));

    instr(K_JUMP, 6'd30, '0, 0, '0, "R11");
    instr(K_PSEL, '0, 4'd2, 0, '0, "R11");
    chk("R11", "page", int'(page_o), 2);
    chk("R11", "addr", int'(addr_o), int'(ref_next(6'd30)));

    a0 = addr_o;
    cyc(0, 1, 0, 0, 6'd4, '0, "R3");
    chk("R3", "busy", int'(busy_o), 1);
    chk("R3", "addr", int'(addr_o), int'(ref_next(a0)));
    chk("R3", "page", int'(page_o), 2);
    cyc(0, 1, 0, 0, 6'd50, '0, "R3");
    chk("R3", "ignored addr", int'(addr_o), 4);
    chk("R3", "busy low", int'(busy_o), 0);

    for (int i = 0; i < 4000; i++) begin
      int r;
      logic [AW-1:0] rx;
      logic [PW-1:0] rz;
      r  = $urandom_range(0, 9);
      rx = AW'($urandom);
      rz = PW'($urandom);
      if (!mbusy) begin
        case (r)
          4:       cyc(0, 0, 1, 0, rx, rz, "RND");
          5:       cyc(1, 0, 0, 0, rx, rz, "RND");
          6, 7:    cyc(0, 1, 0, 0, rx, rz, "RND");
          8:       cyc(0, 0, 0, 1, rx, rz, "RND");
          default: cyc(0, 0, 0, 0, rx, rz, "RND");
        endcase
      end else begin
        if (r < 4)      cyc(0, 0, 1, 0, rx, rz, "RND");
        else if (r < 6) cyc(0, 1, 0, 0, rx, rz, "RND");
        else if (r < 7) cyc(0, 0, 0, 1, rx, rz, "RND");
        else            cyc(0, 0, 0, 0, rx, rz, "RND");
      end
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule